// File: doc/BRIEF.md
# Quadrature Numerically Controlled Oscillator

This block is a numerically controlled oscillator that produces a cosine and a sine sample together on every enabled clock. A 34-bit phase register advances by a programmable tuning word on each enabled edge and wraps modulo 2^34. The output frequency is therefore tune × f_clk / 2^34, and a tuning word of zero gives a constant (DC) pair. The sixteen most significant phase bits address a pipelined CORDIC rotator. Its two top bits select a quadrant, and the rotator turns a gain-compensated vector through the remaining angle. The outputs are signed two's-complement words of amplitude `AMP` (32000 by default).

Two synchronous commands act on the phase register. A clear command forces the phase to zero. A load command writes the bus value into the phase register instead of adding it, which gives a phase jump. Both commands enter at the head of the pipeline, like the tuning word. Samples already inside the rotator therefore drain to the output unchanged, and the discontinuity shows up exactly one latency later. A fresh tuning word may be applied on the very next cycle.

The sample stream has no back-pressure. `cen` is the only stall: while it is low, every register holds. `out_valid` marks the first sample that has passed through the whole pipeline since the asynchronous reset. From then on every enabled edge delivers one sample.

Top module: `nco_quad_top`

## Requirements
- R1: On each edge with `cen` high and no command, the phase register becomes (phase + `tune_word`) mod 2^34. The CORDIC input phase `p` is bits [33:18] of that register.
- R2: A valid output satisfies `cos_out` ≈ AMP·cos(2πp/65536) and `sin_out` ≈ AMP·sin(2πp/65536), each within ±8 LSB, with AMP = 32000. Both words are signed two's complement.
- R3: The sample for the phase written at enabled edge n appears on the outputs right after enabled edge n+30, for a fixed latency of 31 enabled edges.
- R4: With `phase_clr` high on an enabled edge, the phase register becomes zero. `phase_clr` takes priority over `phase_load`. Samples issued earlier still appear unchanged.
- R5: With `phase_load` high (and `phase_clr` low) on an enabled edge, the phase register takes the value of `tune_word`. Samples issued earlier still appear unchanged.
- R6: A tuning word of zero holds the phase, so the output pair stays at a constant value.
- R7: While `cen` is low, `sin_out`, `cos_out` and `out_valid` do not change, and `tune_word`, `phase_clr` and `phase_load` have no effect.
- R8: `out_valid` is low after reset until 31 enabled edges have occurred. It then rises on an enabled edge and stays high until the next reset.
- R9: The quadrant boundary phases 0x0000, 0x4000, 0x8000 and 0xC000 give (cos, sin) = (A,0), (0,A), (−A,0) and (0,−A), within ±8 LSB.
- R10: While `rst_n` is low, the phase register is zero and `sin_out`, `cos_out` and `out_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cen | input | 1 | Clock enable; low stalls the whole pipeline |
| phase_clr | input | 1 | Clear phase to zero on this enabled edge |
| phase_load | input | 1 | Load `tune_word` as the phase on this enabled edge |
| tune_word | input | 34 | Phase increment, or new phase when loading |
| sin_out | output | 16 | Signed sine sample |
| cos_out | output | 16 | Signed cosine sample |
| out_valid | output | 1 | Output samples are valid |

## Verification
The bench targets the exact quadrant boundaries. A design that swaps or mis-signs the quadrant fix-up returns a full-scale value where zero is due, or the wrong sign. Clear and load commands are issued with samples in flight, and both together to test priority. A design that flushes the pipeline, or applies the command at the output, shows the jump one or more cycles early. Long stalls that carry random commands and bus values would expose any register that ignores `cen`. A load near the top of the phase range, followed by increments, would catch an accumulator that saturates instead of wrapping. A valid flag that counts raw clocks instead of enabled ones rises too early once the stalls are mixed in.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // Angle resolution inside the rotator: one full turn = 2**ANG_BITS units.
  localparam int ANG_BITS = 24;
  // Number of entries available in the arctangent step table.
  localparam int ATAN_N = 18;
  // Q16 approximation of the product of cos(atan(2^-i)), valid for 12+ steps.
  localparam int GAIN_Q16 = 39797;

  typedef enum logic [1:0] {
    QUAD_I   = 2'd0,
    QUAD_II  = 2'd1,
    QUAD_III = 2'd2,
    QUAD_IV  = 2'd3
  } quad_e;

  // atan(2^-idx) expressed in units of 2*pi / 2**ANG_BITS.
  function automatic int atan_step(input int idx);
    case (idx)
      0:  return 2097152;
      1:  return 1238021;
      2:  return 654136;
      3:  return 332050;
      4:  return 166669;
      5:  return 83416;
      6:  return 41718;
      7:  return 20860;
      8:  return 10430;
      9:  return 5215;
      10: return 2608;
      11: return 1304;
      12: return 652;
      13: return 326;
      14: return 163;
      15: return 81;
      16: return 41;
      17: return 20;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 34,
  parameter int PH_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen,
  input  logic             clr,
  input  logic             load,
  input  logic [ACC_W-1:0] tune,
  output logic [PH_W-1:0]  phase
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;

  // Clear wins over load; load wins over accumulate.
  always_comb begin
    acc_d = acc_q + tune;
    if (load) acc_d = tune;
    if (clr)  acc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (cen) acc_q <= acc_d;
  end

  assign phase = acc_q[ACC_W-1 -: PH_W];

endmodule

// File: rtl/nco_cordic_stage.sv
module nco_cordic_stage #(
  parameter int XW    = 20,
  parameter int ZW    = 26,
  parameter int SHIFT = 0,
  parameter int ANGLE = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cen,
  input  logic signed [XW-1:0] x_i,
  input  logic signed [XW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  input  nco_pkg::quad_e       q_i,
  output logic signed [XW-1:0] x_o,
  output logic signed [XW-1:0] y_o,
  output logic signed [ZW-1:0] z_o,
  output nco_pkg::quad_e       q_o
);

  localparam logic signed [ZW-1:0] ANG = ANGLE[ZW-1:0];

  logic signed [XW-1:0] x_sh;
  logic signed [XW-1:0] y_sh;
  logic                 rot_neg;

  assign x_sh    = x_i >>> SHIFT;
  assign y_sh    = y_i >>> SHIFT;
  assign rot_neg = z_i[ZW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
      q_o <= nco_pkg::QUAD_I;
    end else if (cen) begin
      if (rot_neg) begin
        x_o <= x_i + y_sh;
        y_o <= y_i - x_sh;
        z_o <= z_i + ANG;
      end else begin
        x_o <= x_i - y_sh;
        y_o <= y_i + x_sh;
        z_o <= z_i - ANG;
      end
      q_o <= q_i;
    end
  end

endmodule

// File: rtl/nco_delay.sv
module nco_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cen,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] sr [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < DEPTH; k++) sr[k] <= '0;
        end else if (cen) begin
          sr[0] <= d;
          for (int k = 1; k < DEPTH; k++) sr[k] <= sr[k-1];
        end
      end
      assign q = sr[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/nco_quad_top.sv
module nco_quad_top #(
  parameter int ACC_W   = 34,
  parameter int PH_W    = 16,
  parameter int OUT_W   = 16,
  parameter int AMP     = 32000,
  parameter int ITER    = 16,
  parameter int LATENCY = 31,
  parameter int FRAC    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cen,
  input  logic                    phase_clr,
  input  logic                    phase_load,
  input  logic [ACC_W-1:0]        tune_word,
  output logic signed [OUT_W-1:0] sin_out,
  output logic signed [OUT_W-1:0] cos_out,
  output logic                    out_valid
);

  import nco_pkg::*;

  // Derived sizes. Stages: phase register, prep, ITER rotations, pad, output.
  localparam int XW    = OUT_W + FRAC + 2;
  localparam int ZW    = ANG_BITS + 2;
  localparam int RW    = PH_W - 2;
  localparam int ZPAD  = ANG_BITS - PH_W;
  localparam int PAD   = LATENCY - 3 - ITER;
  localparam int DW    = 2 * XW + 2;
  localparam longint X0_L = (longint'(AMP) * GAIN_Q16 * (longint'(1) << FRAC)) >>> 16;
  localparam logic signed [XW-1:0] X0  = XW'(X0_L);
  localparam logic signed [XW-1:0] RND = XW'(1) <<< (FRAC - 1);

  // ---------------- phase register ----------------
  logic [PH_W-1:0] phase;

  nco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .cen   (cen),
    .clr   (phase_clr),
    .load  (phase_load),
    .tune  (tune_word),
    .phase (phase)
  );

  // ---------------- quadrant split ----------------
  logic signed [ZW-1:0] z0_q;
  quad_e                q0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z0_q <= '0;
      q0_q <= QUAD_I;
    end else if (cen) begin
      z0_q <= ZW'({phase[RW-1:0], {ZPAD{1'b0}}});
      q0_q <= quad_e'(phase[PH_W-1 -: 2]);
    end
  end

  // ---------------- rotator chain ----------------
  logic signed [XW-1:0] x_s [ITER+1];
  logic signed [XW-1:0] y_s [ITER+1];
  logic signed [ZW-1:0] z_s [ITER+1];
  quad_e                q_s [ITER+1];

  assign x_s[0] = X0;
  assign y_s[0] = '0;
  assign z_s[0] = z0_q;
  assign q_s[0] = q0_q;

  generate
    for (genvar i = 0; i < ITER; i++) begin : g_rot
      nco_cordic_stage #(
        .XW    (XW),
        .ZW    (ZW),
        .SHIFT (i),
        .ANGLE (atan_step(i))
      ) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .cen   (cen),
        .x_i   (x_s[i]),
        .y_i   (y_s[i]),
        .z_i   (z_s[i]),
        .q_i   (q_s[i]),
        .x_o   (x_s[i+1]),
        .y_o   (y_s[i+1]),
        .z_o   (z_s[i+1]),
        .q_o   (q_s[i+1])
      );
    end
  endgenerate

  // ---------------- latency padding ----------------
  logic [DW-1:0]        dly_in;
  logic [DW-1:0]        dly_out;
  logic signed [XW-1:0] xd;
  logic signed [XW-1:0] yd;
  logic [1:0]           qd;

  assign dly_in = {x_s[ITER], y_s[ITER], q_s[ITER]};

  nco_delay #(.W(DW), .DEPTH(PAD)) u_pad (
    .clk   (clk),
    .rst_n (rst_n),
    .cen   (cen),
    .d     (dly_in),
    .q     (dly_out)
  );

  assign {xd, yd, qd} = dly_out;

  // ---------------- rounding and quadrant fix-up ----------------
  logic signed [XW-1:0]    c_full;
  logic signed [XW-1:0]    s_full;
  logic signed [OUT_W-1:0] c_r;
  logic signed [OUT_W-1:0] s_r;
  logic signed [OUT_W-1:0] cos_d;
  logic signed [OUT_W-1:0] sin_d;

  assign c_full = (xd + RND) >>> FRAC;
  assign s_full = (yd + RND) >>> FRAC;
  assign c_r    = c_full[OUT_W-1:0];
  assign s_r    = s_full[OUT_W-1:0];

  always_comb begin
    case (quad_e'(qd))
      QUAD_I:   begin cos_d = c_r;  sin_d = s_r;  end
      QUAD_II:  begin cos_d = -s_r; sin_d = c_r;  end
      QUAD_III: begin cos_d = -c_r; sin_d = -s_r; end
      default:  begin cos_d = s_r;  sin_d = -c_r; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cos_out <= '0;
      sin_out <= '0;
    end else if (cen) begin
      cos_out <= cos_d;
      sin_out <= sin_d;
    end
  end

  // ---------------- valid token chain ----------------
  logic [LATENCY-1:0] tok_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tok_sr <= '0;
    else if (cen) tok_sr <= {tok_sr[LATENCY-2:0], 1'b1};
  end

  assign out_valid = tok_sr[LATENCY-1];

endmodule

// File: rtl/nco_quad_chk.sv
module nco_quad_chk #(
  parameter int OUT_W = 16,
  parameter int AMP   = 32000
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cen,
  input logic signed [OUT_W-1:0] sin_out,
  input logic signed [OUT_W-1:0] cos_out,
  input logic                    out_valid
);

  localparam longint MAG_LO = longint'(AMP - 24) * longint'(AMP - 24);
  localparam longint MAG_HI = longint'(AMP + 24) * longint'(AMP + 24);

  longint mag2;
  assign mag2 = longint'(sin_out) * longint'(sin_out) + longint'(cos_out) * longint'(cos_out);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cen |=> ($stable(sin_out) && $stable(cos_out) && $stable(out_valid)));

  // R8
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);

  // R8
  valid_rise_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(cen));

  // R2
  magnitude_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (mag2 >= MAG_LO && mag2 <= MAG_HI));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && sin_out == '0 && cos_out == '0));

endmodule

bind nco_quad_top nco_quad_chk #(.OUT_W(OUT_W), .AMP(AMP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cen       (cen),
  .sin_out   (sin_out),
  .cos_out   (cos_out),
  .out_valid (out_valid)
);

// File: tb/nco_quad_top_tb.sv
module nco_quad_top_tb;

  localparam int  LAT = 31;
  localparam real A   = 32000.0;
  localparam real TOL = 8.0;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               cen;
  logic               phase_clr;
  logic               phase_load;
  logic [33:0]        tune_word;
  logic signed [15:0] sin_out;
  logic signed [15:0] cos_out;
  logic               out_valid;

  always #10 clk = ~clk;

  nco_quad_top u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cen        (cen),
    .phase_clr  (phase_clr),
    .phase_load (phase_load),
    .tune_word  (tune_word),
    .sin_out    (sin_out),
    .cos_out    (cos_out),
    .out_valid  (out_valid)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  logic [33:0] m_acc;
  logic [33:0] hist [64];
  string       htag [64];
  int          cnt;
  logic signed [15:0] p_sin;
  logic signed [15:0] p_cos;
  logic               p_vld;

  function automatic real ref_wave(input logic [15:0] ph, input bit want_sin);
    real ang;
    ang = 6.283185307179586 * real'(ph) / 65536.0;
    return want_sin ? A * $sin(ang) : A * $cos(ang);
  endfunction

  task automatic near(input string tag, input logic signed [15:0] act, input real exp);
    real d;
    d = real'(act) - exp;
    n_chk++;
    if (d > TOL || d < -TOL) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0.1f", tag, act, exp);
    end
  endtask

  task automatic same(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic snap();
    p_sin = sin_out;
    p_cos = cos_out;
    p_vld = out_valid;
  endtask

  // One clock: drive at the falling edge, model the enabled edge, sample at the next falling edge.
  task automatic tick(input bit e, input bit c, input bit l, input logic [33:0] d);
    int idx;
    cen = e; phase_clr = c; phase_load = l; tune_word = d;
    if (e) begin
      m_acc = c ? 34'd0 : (l ? d : m_acc + d);
      cnt++;
      hist[cnt % 64] = m_acc;
      htag[cnt % 64] = c ? "R4" : (l ? "R5" : "R1");
    end
    @(posedge clk);
    @(negedge clk);
    if (!e) begin
      same("R7 sin hold", sin_out, p_sin);
      same("R7 cos hold", cos_out, p_cos);
      same("R7 valid hold", out_valid, p_vld);
    end
    if (cnt < LAT) begin
      same("R8 valid low", out_valid, 0);
    end else begin
      same("R8 valid high", out_valid, 1);
      idx = (cnt - (LAT - 1)) % 64;
      near({htag[idx], "/R3/R2 sin"}, sin_out, ref_wave(hist[idx][33:18], 1'b1));
      near({htag[idx], "/R3/R2 cos"}, cos_out, ref_wave(hist[idx][33:18], 1'b0));
    end
    snap();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; cen = 1'b0; phase_clr = 1'b0; phase_load = 1'b0; tune_word = '0;
    m_acc = '0; cnt = 0;
    repeat (2) @(negedge clk);
    same("R10 valid", out_valid, 0);
    same("R10 sin", sin_out, 0);
    same("R10 cos", cos_out, 0);
    rst_n = 1'b1;
    snap();

    // R6: zero increment from reset, constant output at phase zero
    repeat (35) tick(1'b1, 1'b0, 1'b0, 34'd0);
    near("R6 const cos", cos_out, A);
    near("R6 const sin", sin_out, 0.0);

    // R9: quadrant boundaries reached by a load, then held
    for (int q = 0; q < 4; q++) begin
      tick(1'b1, 1'b0, 1'b1, {2'(q), 32'd0});
      repeat (LAT - 1) tick(1'b1, 1'b0, 1'b0, 34'd0);
      near("R9 cos", cos_out, (q == 0) ? A : (q == 2) ? -A : 0.0);
      near("R9 sin", sin_out, (q == 1) ? A : (q == 3) ? -A : 0.0);
    end

    // R1: steady sweep with stalls
    repeat (150) tick(($urandom % 4) != 0, 1'b0, 1'b0, 34'h0_0500_0000);

    // R1: wrap through the top of the phase range
    tick(1'b1, 1'b0, 1'b1, 34'h3_FFF0_0000);
    repeat (40) tick(1'b1, 1'b0, 1'b0, 34'h0_0040_0000);

    // R4/R5: clear and load together, clear must win; in-flight samples drain
    tick(1'b1, 1'b1, 1'b1, 34'h1_2345_6789);
    repeat (5) tick(1'b1, 1'b0, 1'b0, 34'h0_0123_4567);
    tick(1'b1, 1'b0, 1'b1, 34'h2_8000_0000);
    repeat (35) tick(1'b1, 1'b0, 1'b0, 34'h0_0123_4567);

    // R7: long stall carrying random commands and bus values
    repeat (12) tick(1'b0, 1'($urandom), 1'($urandom), {2'($urandom), 32'($urandom)});
    repeat (35) tick(1'b1, 1'b0, 1'b0, 34'h0_0010_0000);

    // constrained random mix
    repeat (3000) begin
      tick(($urandom % 8) != 0, ($urandom % 40) == 0, ($urandom % 20) == 0,
           {2'($urandom), 32'($urandom)});
    end

    // R10: asynchronous reset in the middle of a run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    same("R10 mid valid", out_valid, 0);
    same("R10 mid sin", sin_out, 0);
    same("R10 mid cos", cos_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    m_acc = '0; cnt = 0;
    snap();
    repeat (40) tick(1'b1, 1'b0, 1'b0, 34'h0_1000_0000);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule